// File: doc/BRIEF.md
# Variable-Page Fully Associative Address Translator

This block translates 32-bit virtual addresses into physical addresses through a fully associative table of translation entries. Each entry carries its own page-size mask, a tag word (virtual page-pair number, address-space identifier and a global flag) and two mapping words. The two mapping words cover an even page and the odd page next to it. A lookup compares every entry in parallel against the request. The response, one clock later, is either a physical address or one of three fault kinds: no entry matched, the page is marked not present, or the page is clean and the access is a store. Refill and not-present faults are reported separately for loads and for stores.

On every fault the block latches the faulting virtual address and rewrites its context register. The context register then holds the faulting page-pair number and the current address-space identifier, so a handler can reload the table. The low 8 bits of the context register are the current address-space identifier, and software can write the whole register. The entry that last gave a successful translation is remembered and is given priority over the normal lowest-index choice. A free-running pseudo-random generator proposes a victim index at or above a protected ("wired") count. A write port loads whole entries.

Top module: `vp_tlb`

## Requirements
- R1: The page mask of an entry uses only its bits 24:13. An entry's tag, bits 31:13 of its tag word, is compared with the address, but address bits 12:0 and every bit set in the mask are left out of the comparison.
- R2: An entry matches only if the compared tag bits are equal and, in addition, either the entry's identifier (tag-word bits 7:0) equals context bits 7:0 or the entry's global flag (tag-word bit 12) is 1.
- R3: The offset mask is the page mask shifted right by one, ORed with 0xFFF. The address bit just above the offset mask picks the even mapping word when it is 0 and the odd one when it is 1. The frame number is mapping-word bits 25:6. The physical address is that frame placed at bits 31:12, with the offset-mask bits cleared, ORed with the offset bits of the address.
- R4: If the chosen mapping word has its present bit (bit 1) at 0, the lookup reports a not-present fault. The fault is reported on a load-specific output for a load and on a store-specific output for a store.
- R5: If the page is present but its writable bit (bit 2) is 0, a store reports a modify fault. A load to the same page translates normally.
- R6: If no entry matches, the lookup reports a refill fault, on a load-specific or a store-specific output. At most one fault output is high per response, and only together with rsp_valid.
- R7: On any fault, bad_vaddr takes the request address. In the same cycle, ctx_hi becomes {vaddr[31:13], 5'b0, old ctx_hi[7:0]}, and this capture wins over a software context write in that cycle. A successful lookup changes neither register.
- R8: When several entries match, rsp_multi is 1. The remembered last-hit entry wins if it matches; otherwise the lowest-index match wins. Only a successful translation updates the last-hit entry.
- R9: victim_idx always lies between min(wired, ENTRIES-1) and ENTRIES-1 inclusive, and it changes over time as a pseudo-random sequence.
- R10: After reset, all entries are zero, ctx_hi and bad_vaddr are zero, no last hit is remembered, and no response is pending.
- R11: A request with req_valid high at a rising edge is answered at the next rising edge. If a table write happens at the same edge, the lookup sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 1 | Load one table entry |
| tbl_wr_idx | input | IDX_W | Entry index to load |
| tbl_wr_mask | input | 32 | Page mask word (bits 24:13 used) |
| tbl_wr_hi | input | 32 | Tag word: tag 31:13, global 12, identifier 7:0 |
| tbl_wr_lo_even | input | 32 | Even-page mapping word |
| tbl_wr_lo_odd | input | 32 | Odd-page mapping word |
| ctx_wr_en | input | 1 | Software write of the context register |
| ctx_wr_data | input | 32 | Context write value |
| wired | input | IDX_W | Number of protected low entries |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address (zero on a fault) |
| rsp_multi | output | 1 | More than one entry matched |
| flt_refill_ld | output | 1 | No match, load |
| flt_refill_st | output | 1 | No match, store |
| flt_inval_ld | output | 1 | Page not present, load |
| flt_inval_st | output | 1 | Page not present, store |
| flt_modify | output | 1 | Store to clean page |
| bad_vaddr | output | 32 | Last faulting address |
| ctx_hi | output | 32 | Context register |
| victim_idx | output | IDX_W | Suggested replacement index |

## Verification
The assertions assume that wired stays below ENTRIES. They also assume that the request inputs are stable around each rising edge, so the past request values they read back are the values the lookup used. The stimulus changes inputs only on falling edges and uses wired values within range. The stimulus never runs lookups with identifier 0 against the reset-cleared entries, except where a refill is the expected result. Duplicate matches are created on purpose in only one scenario, where the multiple-match flag and the last-hit priority are the outcomes under check.

// File: rtl/vp_tlb_pkg.sv
// Shared entry layout and field helpers for the variable-page translator.
package vp_tlb_pkg;

    localparam logic [31:0] PMASK_FIELD = 32'h01FF_E000;
    localparam logic [31:0] LOW_OFFSET  = 32'h0000_0FFF;
    localparam logic [31:0] PAIR_BITS   = 32'h0000_1FFF;
    localparam int          HI_G_BIT    = 12;
    localparam int          LO_V_BIT    = 1;
    localparam int          LO_D_BIT    = 2;

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] hi;
        logic [31:0] lo_even;
        logic [31:0] lo_odd;
    } tlb_entry_t;

    // Bits of the address that take part in the tag comparison.
    function automatic logic [31:0] tag_keep(input logic [31:0] m);
        return ~((m & PMASK_FIELD) | PAIR_BITS);
    endfunction

    // Bits of the address passed straight through as page offset.
    function automatic logic [31:0] offset_bits(input logic [31:0] m);
        return ((m & PMASK_FIELD) >> 1) | LOW_OFFSET;
    endfunction

endpackage

// File: rtl/vp_tlb_array.sv
// Entry storage with a single write port and a parallel match per entry.
// Assumes the caller keeps wr_idx below ENTRIES; other indices load nothing.
module vp_tlb_array
    import vp_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  tlb_entry_t          wr_data,
    input  logic [31:0]         va,
    input  logic [7:0]          asid,
    output tlb_entry_t          ents [ENTRIES],
    output logic [ENTRIES-1:0]  hits
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        tlb_entry_t ent_q;
        logic       tag_eq;
        logic       id_ok;

        // Load the entry when the write port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q <= '0;
            else if (wr_en && (32'(wr_idx) == i))
                ent_q <= wr_data;
        end

        // Tag and identifier comparison against the live request.
        always_comb begin
            tag_eq  = ((va ^ ent_q.hi) & tag_keep(ent_q.mask)) == 32'h0;
            id_ok   = (ent_q.hi[7:0] == asid) || ent_q.hi[HI_G_BIT];
            hits[i] = tag_eq && id_ok;
            ents[i] = ent_q;
        end
    end

endmodule

// File: rtl/vp_tlb_pick.sv
// Chooses the winning entry, picks the even or odd mapping word, and
// classifies the outcome. Purely combinational.
// Assumes lh_idx is a valid index whenever lh_valid is set.
module vp_tlb_pick
    import vp_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  tlb_entry_t          ents [ENTRIES],
    input  logic [ENTRIES-1:0]  hits,
    input  logic                lh_valid,
    input  logic [IDX_W-1:0]    lh_idx,
    input  logic [31:0]         va,
    input  logic                is_store,
    output logic [IDX_W-1:0]    win_idx,
    output logic                any_hit,
    output logic                multi,
    output logic                not_present,
    output logic                clean_store,
    output logic [31:0]         paddr
);

    logic [IDX_W-1:0] low_idx;
    logic             use_lh;
    tlb_entry_t       win;
    logic [31:0]      off;
    logic [31:0]      lo;

    // Lowest-index matching entry.
    always_comb begin
        low_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) low_idx = IDX_W'(i);
        end
    end

    // Remembered entry takes priority when it still matches.
    always_comb begin
        use_lh  = lh_valid && hits[lh_idx];
        win_idx = use_lh ? lh_idx : low_idx;
        any_hit = |hits;
        multi   = $countones(hits) > 1;
    end

    // Page half selection, fault classification and address formation.
    always_comb begin
        win         = ents[win_idx];
        off         = offset_bits(win.mask);
        lo          = ((va & (off + 32'h1)) != 32'h0) ? win.lo_odd : win.lo_even;
        not_present = !lo[LO_V_BIT];
        clean_store = lo[LO_V_BIT] && !lo[LO_D_BIT] && is_store;
        paddr       = ({lo[25:6], 12'h000} & ~off) | (va & off);
    end

endmodule

// File: rtl/vp_tlb_victim.sv
// Free-running 16-bit LFSR folded into the range [wired, ENTRIES-1].
// Assumes wired is at most ENTRIES-1; larger values are clamped.
module vp_tlb_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] wired,
    output logic [IDX_W-1:0] victim
);

    localparam logic [15:0] SEED = 16'hACE1;

    logic [15:0]      lfsr_q;
    logic [IDX_W-1:0] floor_idx;
    logic [15:0]      span;
    logic [15:0]      rem;

    // Advance the shift register every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr_q <= SEED;
        else
            lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    // Fold the pseudo-random value into the unprotected range.
    always_comb begin
        floor_idx = (32'(wired) > ENTRIES - 1) ? IDX_W'(ENTRIES - 1) : wired;
        span      = 16'(ENTRIES) - 16'(floor_idx);
        rem       = 16'(lfsr_q[7:0]) % span;
        victim    = floor_idx + rem[IDX_W-1:0];
    end

endmodule

// File: rtl/vp_tlb.sv
// Top of the variable-page translator: holds the context, fault-address
// and last-hit registers and registers the one-cycle lookup response.
// Assumes inputs are synchronous to clk and wired < ENTRIES.
module vp_tlb
    import vp_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_wr_en,
    input  logic [IDX_W-1:0] tbl_wr_idx,
    input  logic [31:0]      tbl_wr_mask,
    input  logic [31:0]      tbl_wr_hi,
    input  logic [31:0]      tbl_wr_lo_even,
    input  logic [31:0]      tbl_wr_lo_odd,
    input  logic             ctx_wr_en,
    input  logic [31:0]      ctx_wr_data,
    input  logic [IDX_W-1:0] wired,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic             req_store,
    output logic             rsp_valid,
    output logic [31:0]      rsp_paddr,
    output logic             rsp_multi,
    output logic             flt_refill_ld,
    output logic             flt_refill_st,
    output logic             flt_inval_ld,
    output logic             flt_inval_st,
    output logic             flt_modify,
    output logic [31:0]      bad_vaddr,
    output logic [31:0]      ctx_hi,
    output logic [IDX_W-1:0] victim_idx
);

    tlb_entry_t         wr_data;
    tlb_entry_t         ents [ENTRIES];
    logic [ENTRIES-1:0] hits;
    logic               lh_valid;
    logic [IDX_W-1:0]   lh_idx;
    logic [IDX_W-1:0]   win_idx;
    logic               any_hit;
    logic               multi;
    logic               not_present;
    logic               clean_store;
    logic [31:0]        paddr;
    logic               take_fault;

    // Pack the write-port fields into one entry.
    always_comb begin
        wr_data = '{mask: tbl_wr_mask, hi: tbl_wr_hi,
                    lo_even: tbl_wr_lo_even, lo_odd: tbl_wr_lo_odd};
    end

    vp_tlb_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_wr_idx),
        .wr_data (wr_data),
        .va      (req_vaddr),
        .asid    (ctx_hi[7:0]),
        .ents    (ents),
        .hits    (hits)
    );

    vp_tlb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .ents        (ents),
        .hits        (hits),
        .lh_valid    (lh_valid),
        .lh_idx      (lh_idx),
        .va          (req_vaddr),
        .is_store    (req_store),
        .win_idx     (win_idx),
        .any_hit     (any_hit),
        .multi       (multi),
        .not_present (not_present),
        .clean_store (clean_store),
        .paddr       (paddr)
    );

    vp_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .wired  (wired),
        .victim (victim_idx)
    );

    // A lookup faults when nothing matches or the chosen page refuses it.
    always_comb begin
        take_fault = req_valid && (!any_hit || not_present || clean_store);
    end

    // Register the lookup outcome and track the last successful entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_multi     <= 1'b0;
            flt_refill_ld <= 1'b0;
            flt_refill_st <= 1'b0;
            flt_inval_ld  <= 1'b0;
            flt_inval_st  <= 1'b0;
            flt_modify    <= 1'b0;
            lh_valid      <= 1'b0;
            lh_idx        <= '0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_multi     <= req_valid && multi;
            rsp_paddr     <= '0;
            flt_refill_ld <= 1'b0;
            flt_refill_st <= 1'b0;
            flt_inval_ld  <= 1'b0;
            flt_inval_st  <= 1'b0;
            flt_modify    <= 1'b0;
            if (req_valid) begin
                if (!any_hit) begin
                    flt_refill_st <= req_store;
                    flt_refill_ld <= !req_store;
                end else if (not_present) begin
                    flt_inval_st <= req_store;
                    flt_inval_ld <= !req_store;
                end else if (clean_store) begin
                    flt_modify <= 1'b1;
                end else begin
                    rsp_paddr <= paddr;
                    lh_valid  <= 1'b1;
                    lh_idx    <= win_idx;
                end
            end
        end
    end

    // Capture fault state; a fault overrides a software context write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_vaddr <= '0;
            ctx_hi    <= '0;
        end else if (take_fault) begin
            bad_vaddr <= req_vaddr;
            ctx_hi    <= {req_vaddr[31:13], 5'b0, ctx_hi[7:0]};
        end else if (ctx_wr_en) begin
            ctx_hi <= ctx_wr_data;
        end
    end

endmodule

// File: rtl/vp_tlb_chk.sv
// Port-level checker for vp_tlb, attached by bind below.
// Assumes wired < ENTRIES and inputs stable around rising edges.
module vp_tlb_chk #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [31:0]      req_vaddr,
    input logic             req_store,
    input logic [IDX_W-1:0] wired,
    input logic             rsp_valid,
    input logic             flt_refill_ld,
    input logic             flt_refill_st,
    input logic             flt_inval_ld,
    input logic             flt_inval_st,
    input logic             flt_modify,
    input logic [31:0]      bad_vaddr,
    input logic [31:0]      ctx_hi,
    input logic [IDX_W-1:0] victim_idx
);

    logic [4:0] faults;
    assign faults = {flt_refill_ld, flt_refill_st, flt_inval_ld, flt_inval_st, flt_modify};

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R6
    single_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(faults) <= 1);

    // R6
    fault_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (faults != 5'b0) |-> rsp_valid);

    // R7
    fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (faults != 5'b0) |-> (bad_vaddr == $past(req_vaddr)));

    // R7
    fault_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (faults != 5'b0) |-> (ctx_hi[31:13] == $past(req_vaddr[31:13])
                              && ctx_hi[7:0] == $past(ctx_hi[7:0])));

    // R7
    success_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && faults == 5'b0) |-> $stable(bad_vaddr));

    // R5
    modify_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_modify |-> $past(req_store));

    // R4
    inval_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_inval_ld |-> !$past(req_store)) and (flt_inval_st |-> $past(req_store)));

    // R9
    victim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_idx >= wired) && (32'(victim_idx) <= ENTRIES - 1));

endmodule

bind vp_tlb vp_tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_store     (req_store),
    .wired         (wired),
    .rsp_valid     (rsp_valid),
    .flt_refill_ld (flt_refill_ld),
    .flt_refill_st (flt_refill_st),
    .flt_inval_ld  (flt_inval_ld),
    .flt_inval_st  (flt_inval_st),
    .flt_modify    (flt_modify),
    .bad_vaddr     (bad_vaddr),
    .ctx_hi        (ctx_hi),
    .victim_idx    (victim_idx)
);

// File: tb/vp_tlb_test.sv
`timescale 1ns/1ps
module vp_tlb_test;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_wr_en = 1'b0;
    logic [IW-1:0] tbl_wr_idx = '0;
    logic [31:0]   tbl_wr_mask = '0, tbl_wr_hi = '0, tbl_wr_lo_even = '0, tbl_wr_lo_odd = '0;
    logic          ctx_wr_en = 1'b0;
    logic [31:0]   ctx_wr_data = '0;
    logic [IW-1:0] wired = '0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_vaddr = '0;
    logic          req_store = 1'b0;
    logic          rsp_valid, rsp_multi;
    logic [31:0]   rsp_paddr, bad_vaddr, ctx_hi;
    logic          flt_refill_ld, flt_refill_st, flt_inval_ld, flt_inval_st, flt_modify;
    logic [IW-1:0] victim_idx;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    vp_tlb #(.ENTRIES(N)) uut (.*);

    // Scoreboard item: expected outcome of one lookup.
    typedef struct {
        logic [31:0] pa;
        logic [4:0]  flt;
        logic        multi;
        logic [31:0] bad_va;
        logic [31:0] ctx;
        string       tag;
    } exp_t;
    exp_t q[$];

    // Reference model state.
    logic [31:0] m_mask [N];
    logic [31:0] m_hi   [N];
    logic [31:0] m_lo0  [N];
    logic [31:0] m_lo1  [N];
    logic [31:0] m_ctx, m_bad;
    bit          m_lhv;
    int          m_lh;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model one lookup and push its expected outcome.
    task automatic model_lookup(input logic [31:0] va, input bit st,
                                input bit cwr, input logic [31:0] cdata, input string tag);
        exp_t e;
        int   nhit = 0;
        int   win = -1;
        logic [31:0] keep, off, lo;
        e.pa = 0; e.flt = 0;
        for (int i = 0; i < N; i++) begin
            keep = ~((m_mask[i] & 32'h01FF_E000) | 32'h1FFF);
            if ((((va ^ m_hi[i]) & keep) == 0) &&
                (m_hi[i][7:0] == m_ctx[7:0] || m_hi[i][12])) begin
                nhit++;
                if (win < 0) win = i;
            end
        end
        if (m_lhv) begin
            keep = ~((m_mask[m_lh] & 32'h01FF_E000) | 32'h1FFF);
            if ((((va ^ m_hi[m_lh]) & keep) == 0) &&
                (m_hi[m_lh][7:0] == m_ctx[7:0] || m_hi[m_lh][12])) win = m_lh;
        end
        e.multi = (nhit > 1);
        if (win < 0) begin
            e.flt = st ? 5'b01000 : 5'b10000;
        end else begin
            off = ((m_mask[win] & 32'h01FF_E000) >> 1) | 32'hFFF;
            lo  = ((va & (off + 1)) != 0) ? m_lo1[win] : m_lo0[win];
            if (!lo[1])                e.flt = st ? 5'b00010 : 5'b00100;
            else if (st && !lo[2])     e.flt = 5'b00001;
            else begin
                e.pa  = ({lo[25:6], 12'h0} & ~off) | (va & off);
                m_lhv = 1'b1;
                m_lh  = win;
            end
        end
        if (e.flt != 0) begin
            m_bad = va;
            m_ctx = {va[31:13], 5'b0, m_ctx[7:0]};
        end else if (cwr) begin
            m_ctx = cdata;
        end
        e.bad_va = m_bad;
        e.ctx    = m_ctx;
        e.tag    = tag;
        q.push_back(e);
    endtask

    // Driver: one cycle with an optional table write, context write and lookup.
    task automatic step(input bit twr, input int idx, input logic [31:0] msk, hi, lo0, lo1,
                        input bit cwr, input logic [31:0] cdata,
                        input bit rq, input logic [31:0] va, input bit st, input string tag);
        tbl_wr_en = twr; tbl_wr_idx = IW'(idx); tbl_wr_mask = msk; tbl_wr_hi = hi;
        tbl_wr_lo_even = lo0; tbl_wr_lo_odd = lo1;
        ctx_wr_en = cwr; ctx_wr_data = cdata;
        req_valid = rq; req_vaddr = va; req_store = st;
        if (rq) model_lookup(va, st, cwr, cdata, tag);
        else if (cwr) m_ctx = cdata;
        if (twr) begin
            m_mask[idx] = msk; m_hi[idx] = hi; m_lo0[idx] = lo0; m_lo1[idx] = lo1;
        end
        @(negedge clk);
        tbl_wr_en = 0; ctx_wr_en = 0; req_valid = 0;
    endtask

    task automatic wr_ent(input int idx, input logic [31:0] msk, hi, lo0, lo1);
        step(1, idx, msk, hi, lo0, lo1, 0, 0, 0, 0, 0, "");
    endtask

    task automatic set_ctx(input logic [31:0] d);
        step(0, 0, 0, 0, 0, 0, 1, d, 0, 0, 0, "");
    endtask

    task automatic look(input logic [31:0] va, input bit st, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, va, st, tag);
    endtask

    // Monitor: compare every response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                chk(0, "R11", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({flt_refill_ld, flt_refill_st, flt_inval_ld, flt_inval_st, flt_modify} == e.flt,
                    e.tag, "fault vector",
                    32'({flt_refill_ld, flt_refill_st, flt_inval_ld, flt_inval_st, flt_modify}), 32'(e.flt));
                if (e.flt == 0) chk(rsp_paddr == e.pa, e.tag, "paddr", rsp_paddr, e.pa);
                chk(rsp_multi == e.multi, e.tag, "multi", 32'(rsp_multi), 32'(e.multi));
                chk(bad_vaddr == e.bad_va, e.tag, "bad_vaddr", bad_vaddr, e.bad_va);
                chk(ctx_hi == e.ctx, e.tag, "ctx_hi", ctx_hi, e.ctx);
            end
        end
    end

    task automatic run_tests();
        int seen [N];
        int distinct;
        for (int i = 0; i < N; i++) begin
            m_mask[i] = 0; m_hi[i] = 0; m_lo0[i] = 0; m_lo1[i] = 0;
        end
        m_ctx = 0; m_bad = 0; m_lhv = 0; m_lh = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(rsp_valid == 0, "R10", "rsp_valid after reset", 32'(rsp_valid), 0);
        chk(ctx_hi == 0, "R10", "ctx_hi after reset", ctx_hi, 0);
        chk(bad_vaddr == 0, "R10", "bad_vaddr after reset", bad_vaddr, 0);

        set_ctx(32'h0000_0005);
        look(32'h0002_0123, 0, "R6_refill_ld_R10");
        // e0: 4 KB pages, identifier 5
        wr_ent(0, 32'h0, 32'h0002_0005, 32'h0000_4446, 32'h0000_8882);
        look(32'h0002_0123, 0, "R3_even");
        look(32'h0002_1456, 0, "R3_odd_R5_load_clean");
        look(32'h0002_1456, 1, "R5_modify");
        look(32'h0002_0040, 1, "R5_store_dirty");
        // e1: 16 KB pages, global, mask has stray bits outside 24:13
        wr_ent(1, 32'h8000_6000, 32'h0040_1009, 32'h0000_C002, 32'h0);
        look(32'h0040_2ABC, 0, "R1_R2_global");
        look(32'h0040_4000, 0, "R4_inval_ld");
        look(32'h0040_6010, 1, "R4_inval_st_R7");
        // e2: identifier 7, non-global
        wr_ent(2, 32'h0, 32'h0080_0007, 32'h0001_1106, 32'h0);
        look(32'h0080_0010, 1, "R2_refill_st");
        set_ctx(32'h0000_0007);
        look(32'h0080_0010, 1, "R2_asid_match");
        // R11: same-edge write is not seen by the lookup
        step(1, 2, 32'h0, 32'h0080_0007, 32'h0, 32'h0, 0, 0, 1, 32'h0080_0020, 0, "R11_old_table");
        look(32'h0080_0020, 0, "R11_new_table");
        // R7: fault wins over a same-cycle context write
        step(0, 0, 0, 0, 0, 0, 1, 32'h1234_5007, 1, 32'h0F00_0000, 0, "R7_fault_over_ctx");
        // R8: duplicate entries
        wr_ent(3, 32'h0, 32'h00C0_1000, 32'h0001_5546, 32'h0);
        wr_ent(5, 32'h0, 32'h00C0_1000, 32'h0001_9986, 32'h0);
        look(32'h00C0_0010, 0, "R8_lowest");
        wr_ent(3, 32'h0, 32'h00E0_1000, 32'h0001_5546, 32'h0);
        look(32'h00C0_0010, 0, "R8_single");
        wr_ent(3, 32'h0, 32'h00C0_1000, 32'h0001_5546, 32'h0);
        look(32'h00C0_0010, 0, "R8_last_hit_first");
        @(negedge clk);
        chk(q.size() == 0, "R11", "pending responses", q.size(), 0);

        // R9 victim range and variation
        wired = 3'd5;
        for (int i = 0; i < N; i++) seen[i] = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chk(victim_idx >= 5 && victim_idx <= 7, "R9", "victim in [5,7]", 32'(victim_idx), 5);
            seen[victim_idx] = 1;
        end
        distinct = 0;
        for (int i = 0; i < N; i++) distinct += seen[i];
        chk(distinct >= 2, "R9", "victim varies", distinct, 2);
        wired = 3'd7;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(victim_idx == 7, "R9", "victim at top", 32'(victim_idx), 7);
        end
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (200000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule